// File: doc/BRIEF.md
# Write Protect and Status Unit for a Serial Memory

This block holds the status byte of a serial nonvolatile memory and decides whether each write may go ahead. A serial front end decodes commands and hands this unit single-cycle strobes: set or clear the write enable latch, a status data byte received while the device is selected, and an array write commit carrying the target address. The unit answers every commit, and every status write at the moment selection ends, with a one-cycle grant or deny pulse. A granted write starts a self-timed cycle whose length in system clocks is a parameter. While that cycle runs, the unit reports busy.

Protection combines three things. The two block-protect bits fence off a top quarter, a top half or the whole array. The write-protect pin counts only when the protect-enable bit is set. No write is granted without the write enable latch. A status write waits until selection ends. The protect pin can cancel it before then, but once its timed cycle starts, nothing stops it. The nonvolatile fields come out of reset from parameters and change only when a status cycle completes.

Top module: `wp_status_unit`

## Requirements
- R1: After reset, status_o = {RST_WPEN, 3'b000, RST_BP, 1'b0, 1'b0}, busy_o = 0, and neither grant_o nor deny_o is high.
- R2: The status byte layout is bit 7 protect-enable, bits 6..4 zero, bits 3..2 block-protect (bit 3 high), bit 1 write enable latch, bit 0 busy. When idle, wel_set_i sets bit 1 and wel_clr_i clears it, visible the cycle after the strobe.
- R3: An array commit is granted only when the latch is set, no cycle runs, and the address is outside the protected range. The range is set by the two most significant address bits q: block-protect 00 protects nothing, 01 protects q = 11, 10 protects q = 1x, and 11 protects everything. grant_o or deny_o pulses for one cycle, on the clock edge that samples the commit.
- R4: A granted write holds busy_o high for exactly WCYC_CLKS clocks. During that time status_o reads 8'hFF.
- R5: The write enable latch reads 0 after any array or status write cycle completes.
- R6: A status write stores only data bits 7, 3 and 2. It launches when sel_i falls, is granted when the latch is set and hardware protection is off, and its new fields appear once its cycle ends. All other data bits have no effect.
- R7: Hardware protection is active when wp_n_i = 0 and the protect-enable bit = 1. It denies status writes and leaves the fields unchanged. Array writes outside the block-protected range are still granted.
- R8: If hardware protection becomes active while a status write is pending and sel_i is high, that write is denied when sel_i falls. A low wp_n_i after a status cycle has started does not stop it.
- R9: While busy, latch strobes and status data are ignored, and array commits are denied.
- R10: With the protect-enable bit = 0, wp_n_i = 0 does not block status writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-up reset |
| sel_i | input | 1 | Device selected by the serial front end (high = selected) |
| wp_n_i | input | 1 | Write-protect pin, active low |
| wel_set_i | input | 1 | Set-latch command strobe |
| wel_clr_i | input | 1 | Clear-latch command strobe |
| sr_wr_i | input | 1 | Status data byte received strobe |
| sr_data_i | input | 8 | Status data byte |
| arr_commit_i | input | 1 | Array write commit strobe |
| arr_addr_i | input | ADDR_W | Commit start address |
| status_o | output | 8 | Status byte for reads |
| grant_o | output | 1 | Write accepted pulse |
| deny_o | output | 1 | Write refused pulse |
| busy_o | output | 1 | Timed write cycle running |

## Verification
A corrupted protect-enable or block-protect field shows as a wrong grant or deny on the very next commit or status write, and in status_o once the unit is idle. A stuck or miscounted cycle timer shows as a busy window that is shorter or longer than WCYC_CLKS clocks, or as a latch that survives completion. A cancel path that misses the protect pin shows as a grant in the clock after selection ends, followed by changed fields once the cycle finishes.

// File: rtl/wp_status_pkg.sv
package wp_status_pkg;
   localparam int STATUS_W = 8;

   typedef struct packed {
      logic       wpen;
      logic [1:0] bp;
   } nv_cfg_t;

   function automatic logic [STATUS_W-1:0] pack_status(nv_cfg_t cfg, logic wel, logic busy);
      if (busy) return '1;
      return {cfg.wpen, 3'b000, cfg.bp, wel, 1'b0};
   endfunction

   function automatic nv_cfg_t take_fields(logic [STATUS_W-1:0] d);
      nv_cfg_t c;
      c.wpen = d[7];
      c.bp   = d[3:2];
      return c;
   endfunction
endpackage

// File: rtl/wp_block_guard.sv
module wp_block_guard #(
   parameter int ADDR_W = 13
) (
   input  logic [1:0]        bp_i,
   input  logic [ADDR_W-1:0] addr_i,
   output logic              blocked_o
);
   initial begin
      if (ADDR_W < 2) $error("wp_block_guard: ADDR_W must be at least 2");
   end

   localparam int TOP = ADDR_W - 1;
   logic [1:0] quarter;
   assign quarter = addr_i[TOP -: 2];

   always_comb begin
      unique case (bp_i)
         2'b00:   blocked_o = 1'b0;
         2'b01:   blocked_o = (quarter == 2'b11);
         2'b10:   blocked_o = quarter[1];
         default: blocked_o = 1'b1;
      endcase
   end
endmodule

// File: rtl/wp_cycle_timer.sv
module wp_cycle_timer #(
   parameter int WCYC_CLKS = 40000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   output logic busy_o,
   output logic done_o
);
   initial begin
      if (WCYC_CLKS < 1) $error("wp_cycle_timer: WCYC_CLKS must be at least 1");
   end

   localparam int CNT_W = (WCYC_CLKS > 1) ? $clog2(WCYC_CLKS) : 1;

   generate
      if (WCYC_CLKS == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) busy_o <= 1'b0;
            else        busy_o <= start_i & ~busy_o;
         end
         assign done_o = busy_o;
      end else begin : g_count
         localparam logic [CNT_W-1:0] LAST = CNT_W'(WCYC_CLKS - 1);
         logic [CNT_W-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               busy_o <= 1'b0;
               cnt    <= '0;
            end else if (!busy_o) begin
               if (start_i) begin
                  busy_o <= 1'b1;
                  cnt    <= LAST;
               end
            end else if (cnt == '0) begin
               busy_o <= 1'b0;
            end else begin
               cnt <= cnt - 1'b1;
            end
         end
         assign done_o = busy_o & (cnt == '0);

         assert_cnt_in_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
            busy_o |-> (cnt <= LAST));
         assert_start_loads_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (start_i && !busy_o) |=> (busy_o && cnt == LAST));
      end
   endgenerate
endmodule

// File: rtl/wp_status_unit.sv
module wp_status_unit
   import wp_status_pkg::*;
#(
   parameter int         ADDR_W    = 13,
   parameter int         WCYC_CLKS = 40000,
   parameter logic       RST_WPEN  = 1'b0,
   parameter logic [1:0] RST_BP    = 2'b00
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                sel_i,
   input  logic                wp_n_i,
   input  logic                wel_set_i,
   input  logic                wel_clr_i,
   input  logic                sr_wr_i,
   input  logic [STATUS_W-1:0] sr_data_i,
   input  logic                arr_commit_i,
   input  logic [ADDR_W-1:0]   arr_addr_i,
   output logic [STATUS_W-1:0] status_o,
   output logic                grant_o,
   output logic                deny_o,
   output logic                busy_o
);
   nv_cfg_t nv_q, sr_new_q;
   logic wel_q, sel_q, sr_pend_q, sr_ok_q, cyc_sr_q;
   logic hw_prot, blocked, arr_ok, sr_launch, sr_go, start, done;

   assign hw_prot   = ~wp_n_i & nv_q.wpen;
   assign sr_launch = sel_q & ~sel_i & sr_pend_q;
   assign arr_ok    = arr_commit_i & ~busy_o & wel_q & ~blocked;
   assign sr_go     = sr_launch & sr_ok_q & wel_q & ~busy_o & ~arr_commit_i;
   assign start     = arr_ok | sr_go;

   wp_block_guard #(.ADDR_W(ADDR_W)) guard_i (
      .bp_i     (nv_q.bp),
      .addr_i   (arr_addr_i),
      .blocked_o(blocked)
   );

   wp_cycle_timer #(.WCYC_CLKS(WCYC_CLKS)) timer_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .start_i(start),
      .busy_o (busy_o),
      .done_o (done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q     <= 1'b0;
         grant_o   <= 1'b0;
         deny_o    <= 1'b0;
         cyc_sr_q  <= 1'b0;
      end else begin
         sel_q   <= sel_i;
         grant_o <= start;
         deny_o  <= (arr_commit_i | sr_launch) & ~start;
         if (start) cyc_sr_q <= sr_go;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr_pend_q <= 1'b0;
         sr_ok_q   <= 1'b0;
         sr_new_q  <= '{wpen: RST_WPEN, bp: RST_BP};
      end else if (sr_wr_i && sel_i && !busy_o) begin
         sr_pend_q <= 1'b1;
         sr_ok_q   <= wel_q & ~hw_prot;
         sr_new_q  <= take_fields(sr_data_i);
      end else if (!sel_i) begin
         sr_pend_q <= 1'b0;
      end else if (sr_pend_q && hw_prot) begin
         sr_ok_q   <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wel_q <= 1'b0;
         nv_q  <= '{wpen: RST_WPEN, bp: RST_BP};
      end else if (done) begin
         wel_q <= 1'b0;
         if (cyc_sr_q) nv_q <= sr_new_q;
      end else if (!busy_o) begin
         if (wel_set_i)      wel_q <= 1'b1;
         else if (wel_clr_i) wel_q <= 1'b0;
      end
   end

   assign status_o = pack_status(nv_q, wel_q, busy_o);

   assert_busy_reads_ones_R4: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> (status_o == '1));
   assert_single_answer_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({grant_o, deny_o}));
   assert_latch_cleared_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> !wel_q);
   assert_busy_commit_denied_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (arr_commit_i && busy_o) |=> deny_o);
   assert_full_lock_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (arr_commit_i && nv_q.bp == 2'b11) |=> !grant_o);
   assert_fields_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !done |=> $stable(nv_q));
   assert_grant_needs_latch_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (arr_commit_i && !wel_q) |=> !grant_o);
endmodule

// File: tb/wp_status_unit_tb_top.sv
module wp_status_unit_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int ADDR_W = 13;
   localparam int WCYC = 12;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sel = 1'b0, wp_n = 1'b1, wel_set = 1'b0, wel_clr = 1'b0, sr_wr = 1'b0, commit = 1'b0;
   logic [7:0] sr_data = '0;
   logic [ADDR_W-1:0] addr = '0;
   logic [7:0] status;
   logic grant, deny, busy;

   int compared = 0, mismatched = 0;
   bit exp_q[$];
   string tag_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   wp_status_unit #(.ADDR_W(ADDR_W), .WCYC_CLKS(WCYC), .RST_WPEN(1'b0), .RST_BP(2'b00)) dut_i (
      .clk(clk), .rst_n(rst_n), .sel_i(sel), .wp_n_i(wp_n),
      .wel_set_i(wel_set), .wel_clr_i(wel_clr), .sr_wr_i(sr_wr), .sr_data_i(sr_data),
      .arr_commit_i(commit), .arr_addr_i(addr),
      .status_o(status), .grant_o(grant), .deny_o(deny), .busy_o(busy));

   // monitor: pops one expected answer per grant/deny pulse
   always @(negedge clk) begin
      if (rst_n && (grant || deny)) begin
         compared++;
         if (exp_q.size() == 0) begin
            mismatched++;
            $display("FAIL R3 unexpected answer: actual grant=%0b deny=%0b expected none", grant, deny);
         end else begin
            bit e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            if (grant !== e || deny !== !e) begin
               mismatched++;
               $display("FAIL %s: actual grant=%0b deny=%0b expected grant=%0b", t, grant, deny, e);
            end
         end
      end
   end

   task automatic check_eq(input logic [7:0] act, input logic [7:0] exp, input string tag);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic pulse_set();
      @(negedge clk) wel_set = 1'b1;
      @(negedge clk) wel_set = 1'b0;
   endtask

   task automatic pulse_clr();
      @(negedge clk) wel_clr = 1'b1;
      @(negedge clk) wel_clr = 1'b0;
   endtask

   task automatic do_commit(input logic [ADDR_W-1:0] a, input bit e, input string tag);
      exp_q.push_back(e);
      tag_q.push_back(tag);
      @(negedge clk) begin commit = 1'b1; addr = a; end
      @(negedge clk) commit = 1'b0;
   endtask

   // expect: 0 deny, 1 grant, 2 no answer
   task automatic do_sr(input logic [7:0] d, input int e, input bit drop_wp, input string tag);
      if (e != 2) begin
         exp_q.push_back(e == 1);
         tag_q.push_back(tag);
      end
      @(negedge clk) begin sel = 1'b1; sr_wr = 1'b1; sr_data = d; end
      @(negedge clk) begin sr_wr = 1'b0; if (drop_wp) wp_n = 1'b0; end
      @(negedge clk) sel = 1'b0;
      @(negedge clk);
   endtask

   task automatic wait_idle(output int n);
      n = 0;
      while (busy) begin
         n++;
         @(negedge clk);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      mismatched++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      int n;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_eq(status, 8'h00, "R1 reset status");
      check_eq({5'b0, busy, grant, deny}, 8'h00, "R1 reset flags");

      do_commit(13'h0100, 1'b0, "R3 commit without latch");
      pulse_set();
      check_eq(status, 8'h02, "R2 latch set");
      pulse_clr();
      check_eq(status, 8'h00, "R2 latch cleared");
      pulse_set();

      do_commit(13'h0100, 1'b1, "R3 unprotected commit");
      check_eq(status, 8'hFF, "R4 status during cycle");
      pulse_set();
      do_commit(13'h0200, 1'b0, "R9 commit while busy");
      wait_idle(n);
      check_eq(8'(n), 8'(WCYC - 4), "R4 remaining busy length");
      check_eq(status, 8'h00, "R5 R9 latch cleared and set ignored");

      do_commit(13'h0300, 1'b0, "R5 commit after cycle without latch");
      pulse_set();
      do_commit(13'h0300, 1'b1, "R4 second commit");
      wait_idle(n);
      check_eq(8'(n), 8'(WCYC), "R4 busy length");

      pulse_set();
      do_sr(8'h8E, 1, 1'b0, "R6 status write");
      wait_idle(n);
      check_eq(status, 8'h8C, "R6 fields written, other bits ignored");

      pulse_set();
      do_commit(13'h0000, 1'b0, "R3 full lock");
      check_eq(status, 8'h8E, "R3 status after full-lock deny");

      wp_n = 1'b0;
      do_sr(8'h00, 0, 1'b0, "R7 status write refused");
      check_eq(status, 8'h8E, "R7 fields unchanged");

      wp_n = 1'b1;
      do_sr(8'h84, 1, 1'b0, "R7 pin high allows status write");
      wait_idle(n);
      check_eq(status, 8'h84, "R6 quarter lock");

      wp_n = 1'b0;
      pulse_set();
      do_commit(13'h17FF, 1'b1, "R7 unprotected array under pin");
      wait_idle(n);
      pulse_set();
      do_commit(13'h1800, 1'b0, "R3 top quarter boundary");
      check_eq(status, 8'h86, "R3 latch kept after deny");

      wp_n = 1'b1;
      do_sr(8'h00, 0, 1'b1, "R8 pin drop cancels pending");
      check_eq(status, 8'h86, "R8 fields unchanged after cancel");

      wp_n = 1'b1;
      do_sr(8'h88, 1, 1'b0, "R8 status write started");
      wp_n = 1'b0;
      wait_idle(n);
      check_eq(status, 8'h88, "R8 started cycle completes");

      wp_n = 1'b1;
      pulse_set();
      do_sr(8'h00, 1, 1'b0, "R10 clear protect enable");
      wait_idle(n);
      check_eq(status, 8'h00, "R10 cleared");
      wp_n = 1'b0;
      pulse_set();
      do_sr(8'h08, 1, 1'b0, "R10 pin low with enable off");
      wait_idle(n);
      check_eq(status, 8'h08, "R10 half lock written");

      pulse_set();
      do_commit(13'h1000, 1'b0, "R3 half boundary protected");
      do_commit(13'h0FFF, 1'b1, "R3 half boundary open");
      do_sr(8'h8C, 2, 1'b0, "R9 status data while busy");
      wait_idle(n);
      check_eq(status, 8'h08, "R9 status write while busy ignored");

      repeat (2) @(negedge clk);
      compared++;
      if (exp_q.size() != 0) begin
         mismatched++;
         $display("FAIL R3 missing answers: actual %0d outstanding expected 0", exp_q.size());
      end
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule